// File: doc/BRIEF.md
# Per-Stream Output Bit Advancement Serializer

This block turns parallel time-slot bytes into serial TDM output streams and can launch each stream a few fast-clock ticks ahead of the frame boundary. The lead compensates for the delay that output loading adds later on the line. Everything runs from one timing clock at eight times the 8.192 MHz reference, so a 125 us frame lasts 8192 ticks. A frame pulse sets the tick count.

There are two kinds of stream. Local streams always run at 8.192 Mb/s. Backplane streams run at 16.384 or 32.768 Mb/s, and one shared rate bit picks the speed. Each stream has its own 2-bit advancement code, and one code step is always one tick. At 8.192 Mb/s one step is therefore 1/8 bit, at 16.384 Mb/s it is 1/4 bit and at 32.768 Mb/s it is 1/2 bit.

For each stream the block shows on a slot index output which byte it is sending. It reads that stream's byte input in the same cycle. The codes and the rate bit are taken once per frame, so a frame already on the line is never rearranged.

Top module: `adv_tdm_serializer`

## Requirements
- R1: When fp_i is sampled high at a rising clock edge, the following cycle is tick 0 of a frame. The tick count then rises by one per cycle and wraps from 8191 to 0 with no frame pulse needed.
- R2: A local stream holds each bit for 8 ticks and carries 128 eight-bit slots per frame. loc_slot_o gives the index of the slot being sent, and bit 7 of each byte goes out first.
- R3: A backplane stream holds each bit for 4 ticks (256 slots per frame) when its latched rate bit is 0. It holds each bit for 2 ticks (512 slots per frame) when the bit is 1. bp_slot_o gives the slot index, and bit 7 goes out first.
- R4: Advancement code k (0 to 3) starts bit 7 of slot 0 at tick 8192-k of the preceding frame, or at tick 0 when k is 0. k counts ticks whatever the rate. All later bits follow back to back.
- R5: The byte input of a stream is read in the cycle in which its slot output names that slot. The serial output is a register, so the bit that belongs to tick t is driven during tick t+1.
- R6: The advancement codes and the rate bit are captured only at the end of tick 8187 and apply to the frame that starts next. A change made at any other tick has no effect until the next capture.
- R7: When a stream's code changes from one frame to the next, the new frame still starts complete at its own start tick. With a smaller code, the last bit of the old frame is held until that tick. With a larger code, that last bit is cut short.
- R8: While rst_ni is low, every serial output is 0, every slot output is 0, all codes read as 0 and the rate reads as 16.384 Mb/s. The frame right after reset runs with those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, 8 x 8.192 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse; next cycle is tick 0 |
| bp_rate_i | input | 1 | Backplane rate: 0 = 16.384 Mb/s, 1 = 32.768 Mb/s |
| loc_adv_i | input | N_LOC x ADV_W | Advancement code per local stream |
| bp_adv_i | input | N_BP x ADV_W | Advancement code per backplane stream |
| loc_data_i | input | N_LOC x 8 | Byte for the slot named on loc_slot_o |
| bp_data_i | input | N_BP x 8 | Byte for the slot named on bp_slot_o |
| loc_slot_o | output | N_LOC x 7 | Slot index being sent, per local stream |
| bp_slot_o | output | N_BP x 9 | Slot index being sent, per backplane stream |
| loc_sout_o | output | N_LOC | Serial local outputs |
| bp_sout_o | output | N_BP | Serial backplane outputs |

## Verification
The bench compares every serial bit and every slot index with a per-tick model, one frame at a time. It uses fixed, equal codes first and mixed codes per stream later. This separates a stream that takes the wrong code or the wrong bit period from one that is only misaligned. Directed frames step the codes from 0 to 3 and back, so both the held last bit and the cut last bit at a frame boundary are seen. One frame changes the codes right after the capture tick, which shows whether a late change leaks into the frame that follows. Seeded random frames then vary the codes, the rate and the tick of the change around the capture point.

// File: rtl/adv_tdm_pkg.sv
package adv_tdm_pkg;
  localparam int unsigned BYTE_BITS   = 8;
  localparam int unsigned LOC_SHIFT   = 3;  // 8 ticks per bit
  localparam int unsigned BP_SHIFT_16 = 2;  // 4 ticks per bit
  localparam int unsigned BP_SHIFT_32 = 1;  // 2 ticks per bit

  typedef logic [1:0] shift_t;

  typedef enum logic {
    RATE_16M = 1'b0,
    RATE_32M = 1'b1
  } bp_rate_e;

  function automatic shift_t bp_shift(input bp_rate_e rate);
    return (rate == RATE_32M) ? shift_t'(BP_SHIFT_32) : shift_t'(BP_SHIFT_16);
  endfunction
endpackage

// File: rtl/adv_frame_timer.sv
module adv_frame_timer #(
  parameter int unsigned FRAME_TICKS = 8192,
  parameter int unsigned TICK_W      = $clog2(FRAME_TICKS),
  parameter int unsigned LATCH_LEAD  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_i,
  input  logic              rate_i,
  output logic [TICK_W-1:0] tick_o,
  output logic [TICK_W-1:0] tick_nxt_o,
  output logic              latch_o,
  output logic              rate_lat_o
);
  localparam logic [TICK_W-1:0] LAST_TICK  = TICK_W'(FRAME_TICKS - 1);
  localparam logic [TICK_W-1:0] LATCH_TICK = TICK_W'(FRAME_TICKS - LATCH_LEAD);

  logic [TICK_W-1:0] tick_q, tick_d;
  logic              rate_q;

  always_comb begin
    if (fp_i)                   tick_d = '0;
    else if (tick_q == LAST_TICK) tick_d = '0;
    else                        tick_d = tick_q + 1'b1;
  end

  assign latch_o = (tick_q == LATCH_TICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      rate_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      if (latch_o) rate_q <= rate_i;
    end
  end

  assign tick_o     = tick_q;
  assign tick_nxt_o = tick_d;
  assign rate_lat_o = rate_q;
endmodule

// File: rtl/adv_stream_phase.sv
module adv_stream_phase
  import adv_tdm_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 8192,
  parameter int unsigned TICK_W      = $clog2(FRAME_TICKS),
  parameter int unsigned ADV_W       = 2,
  parameter int unsigned RST_SHIFT   = LOC_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic [TICK_W-1:0] tick_nxt_i,
  input  logic [ADV_W-1:0]  adv_i,
  input  shift_t            next_shift_i,
  output logic [TICK_W-1:0] pos_o,
  output shift_t            shift_o
);
  localparam logic [TICK_W-1:0] LAST_POS = TICK_W'(FRAME_TICKS - 1);

  logic [ADV_W-1:0]  adv_q;
  logic [TICK_W-1:0] pos_q, pos_d, start_tick;
  shift_t            shift_q;
  logic              restart;

  // own frame starts adv_q ticks before the common boundary (wraps to 0 for code 0)
  assign start_tick = TICK_W'(FRAME_TICKS - 32'(adv_q));
  assign restart    = (tick_nxt_i == start_tick);

  always_comb begin
    if (restart)               pos_d = '0;
    else if (pos_q == LAST_POS) pos_d = pos_q;  // hold last bit until own restart
    else                       pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adv_q   <= '0;
      pos_q   <= '0;
      shift_q <= shift_t'(RST_SHIFT);
    end else begin
      if (latch_i) adv_q <= adv_i;
      pos_q <= pos_d;
      if (restart) shift_q <= next_shift_i;
    end
  end

  assign pos_o   = pos_q;
  assign shift_o = shift_q;
endmodule

// File: rtl/adv_stream_tx.sv
module adv_stream_tx
  import adv_tdm_pkg::*;
#(
  parameter int unsigned TICK_W = 13,
  parameter int unsigned SLOT_W = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TICK_W-1:0]    pos_i,
  input  shift_t               shift_i,
  input  logic [BYTE_BITS-1:0] data_i,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 sout_o
);
  logic [TICK_W-1:0] bit_pos;
  logic [2:0]        bit_sel;
  logic              sout_q;

  assign bit_pos = pos_i >> shift_i;
  assign bit_sel = bit_pos[2:0];
  assign slot_o  = SLOT_W'(bit_pos >> 3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sout_q <= 1'b0;
    else         sout_q <= data_i[~bit_sel];  // msb first
  end

  assign sout_o = sout_q;
endmodule

// File: rtl/adv_tdm_serializer.sv
module adv_tdm_serializer
  import adv_tdm_pkg::*;
#(
  parameter int unsigned N_LOC       = 2,
  parameter int unsigned N_BP        = 2,
  parameter int unsigned FRAME_TICKS = 8192,
  parameter int unsigned ADV_W       = 2,
  localparam int unsigned TICK_W     = $clog2(FRAME_TICKS),
  localparam int unsigned LOC_SLOT_W = TICK_W - LOC_SHIFT - 3,
  localparam int unsigned BP_SLOT_W  = TICK_W - BP_SHIFT_32 - 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             fp_i,
  input  logic                             bp_rate_i,
  input  logic [N_LOC-1:0][ADV_W-1:0]      loc_adv_i,
  input  logic [N_BP-1:0][ADV_W-1:0]       bp_adv_i,
  input  logic [N_LOC-1:0][BYTE_BITS-1:0]  loc_data_i,
  input  logic [N_BP-1:0][BYTE_BITS-1:0]   bp_data_i,
  output logic [N_LOC-1:0][LOC_SLOT_W-1:0] loc_slot_o,
  output logic [N_BP-1:0][BP_SLOT_W-1:0]   bp_slot_o,
  output logic [N_LOC-1:0]                 loc_sout_o,
  output logic [N_BP-1:0]                  bp_sout_o
);
  // capture point leaves room for the largest advancement plus one cycle
  localparam int unsigned LATCH_LEAD = (2 ** ADV_W) + 1;

  logic [TICK_W-1:0]             tick_w, tick_nxt_w;
  logic                          latch_w, rate_lat_w;
  shift_t                        bp_next_shift_w;
  logic [N_LOC-1:0][TICK_W-1:0]  loc_pos_w;
  shift_t [N_LOC-1:0]            loc_shift_w;
  logic [N_BP-1:0][TICK_W-1:0]   bp_pos_w;
  shift_t [N_BP-1:0]             bp_shift_w;

  adv_frame_timer #(
    .FRAME_TICKS(FRAME_TICKS),
    .TICK_W     (TICK_W),
    .LATCH_LEAD (LATCH_LEAD)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fp_i      (fp_i),
    .rate_i    (bp_rate_i),
    .tick_o    (tick_w),
    .tick_nxt_o(tick_nxt_w),
    .latch_o   (latch_w),
    .rate_lat_o(rate_lat_w)
  );

  assign bp_next_shift_w = bp_shift(bp_rate_e'(rate_lat_w));

  for (genvar s = 0; s < N_LOC; s++) begin : g_loc
    adv_stream_phase #(
      .FRAME_TICKS(FRAME_TICKS),
      .TICK_W     (TICK_W),
      .ADV_W      (ADV_W),
      .RST_SHIFT  (LOC_SHIFT)
    ) u_phase (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .latch_i     (latch_w),
      .tick_nxt_i  (tick_nxt_w),
      .adv_i       (loc_adv_i[s]),
      .next_shift_i(shift_t'(LOC_SHIFT)),
      .pos_o       (loc_pos_w[s]),
      .shift_o     (loc_shift_w[s])
    );

    adv_stream_tx #(
      .TICK_W(TICK_W),
      .SLOT_W(LOC_SLOT_W)
    ) u_tx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pos_i  (loc_pos_w[s]),
      .shift_i(loc_shift_w[s]),
      .data_i (loc_data_i[s]),
      .slot_o (loc_slot_o[s]),
      .sout_o (loc_sout_o[s])
    );
  end

  for (genvar s = 0; s < N_BP; s++) begin : g_bp
    adv_stream_phase #(
      .FRAME_TICKS(FRAME_TICKS),
      .TICK_W     (TICK_W),
      .ADV_W      (ADV_W),
      .RST_SHIFT  (BP_SHIFT_16)
    ) u_phase (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .latch_i     (latch_w),
      .tick_nxt_i  (tick_nxt_w),
      .adv_i       (bp_adv_i[s]),
      .next_shift_i(bp_next_shift_w),
      .pos_o       (bp_pos_w[s]),
      .shift_o     (bp_shift_w[s])
    );

    adv_stream_tx #(
      .TICK_W(TICK_W),
      .SLOT_W(BP_SLOT_W)
    ) u_tx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pos_i  (bp_pos_w[s]),
      .shift_i(bp_shift_w[s]),
      .data_i (bp_data_i[s]),
      .slot_o (bp_slot_o[s]),
      .sout_o (bp_sout_o[s])
    );
  end
endmodule

// File: rtl/adv_tdm_serializer_chk.sv
module adv_tdm_serializer_chk
  import adv_tdm_pkg::*;
#(
  parameter int unsigned N_LOC       = 2,
  parameter int unsigned N_BP        = 2,
  parameter int unsigned FRAME_TICKS = 8192,
  parameter int unsigned ADV_W       = 2,
  localparam int unsigned TICK_W     = $clog2(FRAME_TICKS),
  localparam int unsigned LOC_SLOT_W = TICK_W - LOC_SHIFT - 3,
  localparam int unsigned BP_SLOT_W  = TICK_W - BP_SHIFT_32 - 3
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             fp_i,
  input logic [TICK_W-1:0]                tick_w,
  input logic [N_LOC-1:0][LOC_SLOT_W-1:0] loc_slot_o,
  input logic [N_LOC-1:0][BYTE_BITS-1:0]  loc_data_i,
  input logic [N_LOC-1:0]                 loc_sout_o,
  input logic [N_BP-1:0][BP_SLOT_W-1:0]   bp_slot_o,
  input logic [N_BP-1:0][BYTE_BITS-1:0]   bp_data_i,
  input logic [N_BP-1:0]                  bp_sout_o,
  input logic [N_LOC-1:0][TICK_W-1:0]     loc_pos_w,
  input shift_t [N_LOC-1:0]               loc_shift_w,
  input logic [N_BP-1:0][TICK_W-1:0]      bp_pos_w,
  input shift_t [N_BP-1:0]                bp_shift_w
);
  localparam logic [TICK_W-1:0] WIN_LO = TICK_W'(FRAME_TICKS - (2 ** ADV_W - 1));

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_fp_tick_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (tick_w == '0));

  for (genvar s = 0; s < N_LOC; s++) begin : g_loc_chk
    p_loc_msb_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && (loc_slot_o[s] != $past(loc_slot_o[s])))
      |=> (loc_sout_o[s] == $past(loc_data_i[s][7])));

    p_loc_slot_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && (loc_slot_o[s] != $past(loc_slot_o[s])))
      |-> ((loc_slot_o[s] == $past(loc_slot_o[s]) + 1'b1) || (loc_slot_o[s] == '0)));

    p_loc_start_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loc_pos_w[s] == '0) |-> ((tick_w == '0) || (tick_w >= WIN_LO)));

    p_loc_shift_at_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && (loc_shift_w[s] != $past(loc_shift_w[s]))) |-> (loc_pos_w[s] == '0));
  end

  for (genvar s = 0; s < N_BP; s++) begin : g_bp_chk
    p_bp_msb_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && (bp_slot_o[s] != $past(bp_slot_o[s])))
      |=> (bp_sout_o[s] == $past(bp_data_i[s][7])));

    p_bp_slot_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && (bp_slot_o[s] != $past(bp_slot_o[s])))
      |-> ((bp_slot_o[s] == $past(bp_slot_o[s]) + 1'b1) || (bp_slot_o[s] == '0)));

    p_bp_start_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bp_pos_w[s] == '0) |-> ((tick_w == '0) || (tick_w >= WIN_LO)));

    p_bp_shift_at_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && (bp_shift_w[s] != $past(bp_shift_w[s]))) |-> (bp_pos_w[s] == '0));
  end
endmodule

bind adv_tdm_serializer adv_tdm_serializer_chk #(
  .N_LOC      (N_LOC),
  .N_BP       (N_BP),
  .FRAME_TICKS(FRAME_TICKS),
  .ADV_W      (ADV_W)
) u_chk (.*);

// File: tb/adv_tdm_serializer_tb_top.sv
module adv_tdm_serializer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_LOC = 2;
  localparam int N_BP  = 2;
  localparam int NS    = N_LOC + N_BP;
  localparam int FT    = 8192;
  localparam int NF    = 10;
  localparam int CAP_T = FT - 5;  // R6 capture tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp = 1'b0;
  logic rate = 1'b0;
  logic [N_LOC-1:0][1:0] loc_adv = '0;
  logic [N_BP-1:0][1:0]  bp_adv = '0;
  logic [N_LOC-1:0][7:0] loc_data;
  logic [N_BP-1:0][7:0]  bp_data;
  logic [N_LOC-1:0][6:0] loc_slot;
  logic [N_BP-1:0][8:0]  bp_slot;
  logic [N_LOC-1:0]      loc_sout;
  logic [N_BP-1:0]       bp_sout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int a_cur [NS];
  int a_nxt [NS];
  int sh_cur[NS];
  int sh_nxt[NS];
  logic prev_exp[NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  adv_tdm_serializer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .fp_i      (fp),
    .bp_rate_i (rate),
    .loc_adv_i (loc_adv),
    .bp_adv_i  (bp_adv),
    .loc_data_i(loc_data),
    .bp_data_i (bp_data),
    .loc_slot_o(loc_slot),
    .bp_slot_o (bp_slot),
    .loc_sout_o(loc_sout),
    .bp_sout_o (bp_sout)
  );

  function automatic logic [7:0] pat(input int s, input int slot);
    return 8'(((slot * 29) + (s * 71) + 60) ^ (slot >> 3));
  endfunction

  // byte source: memory-like lookup by slot index
  always_comb begin
    for (int s = 0; s < N_LOC; s++) loc_data[s] = pat(s, int'(loc_slot[s]));
    for (int s = 0; s < N_BP; s++)  bp_data[s]  = pat(N_LOC + s, int'(bp_slot[s]));
  end

  // expected slot and bit of stream s at tick t (R2, R3, R4, R7)
  task automatic calc(input int s, input int t, output int slot, output logic b);
    int p, sh, bp;
    logic [7:0] by;
    if ((a_nxt[s] != 0) && (t >= FT - a_nxt[s])) begin
      p  = t - (FT - a_nxt[s]);
      sh = sh_nxt[s];
    end else begin
      p  = t + a_cur[s];
      if (p > FT - 1) p = FT - 1;
      sh = sh_cur[s];
    end
    bp   = p >> sh;
    slot = bp >> 3;
    by   = pat(s, slot);
    b    = by[7 - (bp % 8)];
  endtask

  function automatic string tag_of(input int s, input int f, input int t);
    if (f == 0) return "R8";
    if (f == 4) return "R6";
    if ((t >= FT - 4) || (t == 0)) return "R7";
    if (a_cur[s] != 0) return "R4";
    return (s < N_LOC) ? "R2" : "R3";
  endfunction

  task automatic check_val(input string tag, input int s, input int f, input int t,
                           input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      if (failures <= 20)
        $display("FAIL %s stream %0d frame %0d tick %0d actual=%0d expected=%0d",
                 tag, s, f, t, act, exp_v);
    end
  endtask

  function automatic int act_sout(input int s);
    return (s < N_LOC) ? int'(loc_sout[s]) : int'(bp_sout[s - N_LOC]);
  endfunction

  function automatic int act_slot(input int s);
    return (s < N_LOC) ? int'(loc_slot[s]) : int'(bp_slot[s - N_LOC]);
  endfunction

  task automatic set_codes(input int l0, input int l1, input int b0, input int b1, input logic r);
    loc_adv[0] = 2'(l0);
    loc_adv[1] = 2'(l1);
    bp_adv[0]  = 2'(b0);
    bp_adv[1]  = 2'(b1);
    rate       = r;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    int seed_v;
    int chg_t;
    int slot_e;
    logic bit_e;
    bit have_prev;
    seed_v = $urandom(32'h2417);
    have_prev = 1'b0;
    for (int s = 0; s < NS; s++) begin
      a_cur[s] = 0;
      a_nxt[s] = 0;
      sh_cur[s] = (s < N_LOC) ? 3 : 2;
      sh_nxt[s] = sh_cur[s];
    end

    // R8: reset values at the ports
    repeat (3) @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      check_val("R8", s, 0, 0, act_sout(s), 0);
      check_val("R8", s, 0, 0, act_slot(s), 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    fp = 1'b1;  // R1: next cycle becomes tick 0

    for (int f = 0; f < NF; f++) begin
      case (f)
        3:       chg_t = FT - 4;  // R6: change right after capture
        default: chg_t = (f < 3) ? 100 : (FT - 7 + ($urandom % 4));
      endcase
      for (int t = 0; t < FT; t++) begin
        @(negedge clk);
        // R5: bit of tick t-1 is on the output during tick t
        if (have_prev) begin
          for (int s = 0; s < NS; s++)
            check_val(tag_of(s, f, t), s, f, t, act_sout(s), int'(prev_exp[s]));
        end
        if (t == chg_t) begin
          case (f)
            0: set_codes(3, 3, 3, 3, 1'b1);
            1: set_codes(0, 0, 0, 0, 1'b0);
            2: set_codes(1, 2, 3, 1, 1'b1);
            3: set_codes(2, 2, 2, 2, 1'b0);
            default: set_codes($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
                               1'($urandom % 2));
          endcase
        end
        fp = (t == FT - 1);
        if (t == CAP_T) begin
          for (int s = 0; s < N_LOC; s++) begin
            a_nxt[s] = int'(loc_adv[s]);
            sh_nxt[s] = 3;
          end
          for (int s = 0; s < N_BP; s++) begin
            a_nxt[N_LOC + s] = int'(bp_adv[s]);
            sh_nxt[N_LOC + s] = rate ? 1 : 2;
          end
        end
        for (int s = 0; s < NS; s++) begin
          calc(s, t, slot_e, bit_e);
          // R2, R3: slot index of the byte in flight
          check_val((s < N_LOC) ? "R2" : "R3", s, f, t, act_slot(s), slot_e);
          prev_exp[s] = bit_e;
        end
        have_prev = 1'b1;
        if (t == FT - 1) begin
          for (int s = 0; s < NS; s++) begin
            a_cur[s] = a_nxt[s];
            sh_cur[s] = sh_nxt[s];
          end
        end
      end
    end
    @(negedge clk);
    for (int s = 0; s < NS; s++)
      check_val("R7", s, NF, 0, act_sout(s), int'(prev_exp[s]));
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule